// File: doc/BRIEF.md
# Touch-panel ADC scan sequencer

This block drives a serial touch-panel converter with eight analog inputs over a four-wire SPI link in clock mode 0. A single start pulse takes a snapshot of an eight-bit channel-enable mask. The block then visits each enabled input in rising address order. For every input it sends a run of 24-bit frames. Each frame is one command byte followed by a 16-bit reply window. Chip select stays low from the first frame of the scan to the last.

Each input has its own settling time in nanoseconds and its own oversampling ratio. The settling time is turned into a number of leading frames whose replies are discarded. The next ratio frames are kept. Their 12-bit samples are summed, and the sum is divided by the ratio with the quotient rounded up. The averaged result goes out on a write strobe with a slot index. Slots are filled from zero upward without gaps, so the consumer receives a dense list of results. A one-cycle done pulse closes the scan.

Top module: `touch_scan_seq`

## Requirements
- R1: The command byte is {start=1, address[2:0], 8-bit-mode=0, single-ended, reference-on, converter-on}, sent MSB first. Addresses 0, 2, 6 and 7 set the single-ended bit, and addresses 1, 3, 4 and 5 clear it. Converter-on is 1 on every frame of an input except its last. Reference-on is 1 only when the single-ended bit is set, `int_ref` is high and the frame is not the last.
- R2: An enabled input gets skip + ratio frames. skip = ceil(ceil(settle_ns / BIT_NS) / 24), where BIT_NS = ceil(2·SCLK_HDIV·1e9 / SYS_CLK_HZ). A ratio of 0 counts as 1.
- R3: The result is the ceiling of the sum of the kept samples divided by the ratio. A sample is bits 14:3 of the 16-bit reply, so bits outside that field have no effect. No overflow occurs for ratios up to 255 with full-scale samples.
- R4: Results for enabled inputs come out in ascending address order. Each is a one-cycle `res_we` with `res_slot` numbered 0, 1, 2 and so on. There is exactly one write per enabled input.
- R5: SPI mode 0. `sclk` idles low. `mosi` changes only after a falling edge. `miso` is sampled on the rising edge. Each `sclk` half period lasts SCLK_HDIV clock cycles.
- R6: `cs_n` falls once before the first frame and rises once after the last frame of the scan. `sclk` is never high while `cs_n` is high. An empty mask produces no chip-select activity.
- R7: `done` pulses for exactly one cycle after the final result write. `busy` is high from the cycle after start until `done`.
- R8: A start pulse while busy is ignored. The scan in flight keeps its snapshot mask and produces exactly one `done`.
- R9: After reset, `cs_n`=1, `sclk`=0, and `busy`, `done` and `res_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan request pulse |
| ch_en | input | NCH | Channel-enable mask, sampled at start |
| int_ref | input | 1 | Selects the converter's internal reference |
| settle_ns | input | NCH*SETTLE_W | Per-input settling time in ns |
| ratio | input | NCH*RATIO_W | Per-input oversampling ratio |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| res_we | output | 1 | Result write strobe |
| res_slot | output | $clog2(NCH) | Result slot index |
| res_data | output | 12 | Rounded-up average |

## Verification
The bench plays the converter side of the link. It returns replies whose command-byte window and reply bits 15 and 2:0 carry junk. A design that takes the wrong field or samples on the wrong edge therefore returns wrong averages. The bench targets these cases:
- Sums that do not divide evenly. Truncating instead of rounding up gives an answer one too low.
- A zero settling time and a zero ratio. Off-by-one frame counts would show up as a changed frame total.
- 255 full-scale samples. An accumulator that is too narrow would wrap.
- The last-frame power bits. A design that keeps them set, or drops them one frame early, gives a wrong command byte.
- A start pulse in the middle of a scan. A design that restarts would produce extra frames and a second done.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_LAUNCH, S_FRAME, S_DSTART, S_DIV, S_FIN
  } scan_st_t;

  // Command byte: start, address, 12-bit mode, single-ended, ref on, adc on
  function automatic logic [7:0] mk_cmd(input logic [2:0] addr,
                                        input logic       last,
                                        input logic       int_ref);
    logic se;
    se = (addr == 3'd0) || (addr == 3'd2) || (addr == 3'd6) || (addr == 3'd7);
    mk_cmd = {1'b1, addr, 1'b0, se, se & int_ref & ~last, ~last};
  endfunction

endpackage

// File: rtl/tscan_shifter.sv
module tscan_shifter #(
  parameter int HDIV = 4,
  parameter int FW   = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [FW-1:0] frame_in,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          active,
  output logic          fdone,
  output logic [FW-1:0] rx
);
  localparam int HCW = (HDIV > 1) ? $clog2(HDIV) : 1;
  localparam int BW  = $clog2(FW);

  logic [HCW-1:0] cnt;
  logic [BW-1:0]  bitn;
  logic [FW-1:0]  tx;

  always_ff @(posedge clk) begin
    fdone <= 1'b0;
    if (rst) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      tx     <= '0;
      rx     <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        tx     <= frame_in;
        cnt    <= '0;
        bitn   <= '0;
      end
    end else if (cnt == HCW'(HDIV - 1)) begin
      cnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
        rx   <= {rx[FW-2:0], miso};
      end else begin
        sclk <= 1'b0;
        tx   <= {tx[FW-2:0], 1'b0};
        if (bitn == BW'(FW - 1)) begin
          active <= 1'b0;
          fdone  <= 1'b1;
        end else begin
          bitn <= bitn + 1'b1;
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mosi = tx[FW-1];

  // R5: clock rests low outside a frame
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);

  // R5: a new frame is only launched once the previous one has ended
  a_r5_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    go |-> !active);

endmodule

// File: rtl/tscan_cdiv.sv
module tscan_cdiv #(
  parameter int NW = 21,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem;
  logic [NW-1:0] q;
  logic [DW-1:0] d;
  logic [CW-1:0] left;
  logic          run;
  logic [DW:0]   trial;

  assign trial = {rem[DW-1:0], q[NW-1]};

  always_ff @(posedge clk) begin
    fin <= 1'b0;
    if (rst) begin
      run  <= 1'b0;
      rem  <= '0;
      q    <= '0;
      d    <= '0;
      left <= '0;
    end else if (go && !run) begin
      run  <= 1'b1;
      rem  <= '0;
      q    <= num + NW'(den) - NW'(1);   // bias for round-up
      d    <= den;
      left <= CW'(NW);
    end else if (run) begin
      if (trial >= {1'b0, d}) begin
        rem <= trial - {1'b0, d};
        q   <= {q[NW-2:0], 1'b1};
      end else begin
        rem <= trial;
        q   <= {q[NW-2:0], 1'b0};
      end
      left <= left - 1'b1;
      if (left == CW'(1)) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end
  end

  assign quo = q;

endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
  import tscan_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int SCLK_HDIV  = 10,
  parameter int SETTLE_W   = 16,
  parameter int RATIO_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NCH-1:0]          ch_en,
  input  logic                    int_ref,
  input  logic [NCH*SETTLE_W-1:0] settle_ns,
  input  logic [NCH*RATIO_W-1:0]  ratio,
  input  logic                    miso,
  output logic                    sclk,
  output logic                    mosi,
  output logic                    cs_n,
  output logic                    busy,
  output logic                    done,
  output logic                    res_we,
  output logic [$clog2(NCH)-1:0]  res_slot,
  output logic [11:0]             res_data
);
  localparam int AW      = $clog2(NCH);
  localparam int RES_W   = 12;
  localparam int FRAME_W = 24;
  localparam int CNT_W   = ((SETTLE_W > RATIO_W) ? SETTLE_W : RATIO_W) + 1;
  localparam int ACC_W   = RES_W + RATIO_W;
  localparam int DIVN_W  = ACC_W + 1;
  localparam int unsigned BIT_NS =
    32'((64'd2 * 64'(SCLK_HDIV) * 64'd1000000000 + 64'(SYS_CLK_HZ) - 64'd1) / 64'(SYS_CLK_HZ));

  scan_st_t st;
  logic [NCH-1:0]      mask;
  logic [AW:0]         ch;
  logic [AW-1:0]       ch_lo, slot;
  logic [CNT_W-1:0]    fidx, total, skip_r;
  logic [RATIO_W-1:0]  ratio_r, ratio_cur, ratio_eff;
  logic [SETTLE_W-1:0] settle_cur;
  logic [ACC_W-1:0]    acc;
  logic [31:0]         bits_c, skip_c;
  logic                fr_go, fr_active, fdone, div_go, div_fin;
  logic [FRAME_W-1:0]  frame_in, rx;
  logic [RES_W-1:0]    sample;
  logic [DIVN_W-1:0]   div_q;

  assign ch_lo      = ch[AW-1:0];
  assign settle_cur = settle_ns[ch_lo*SETTLE_W +: SETTLE_W];
  assign ratio_cur  = ratio[ch_lo*RATIO_W +: RATIO_W];
  assign ratio_eff  = (ratio_cur == '0) ? RATIO_W'(1) : ratio_cur;

  always_comb begin
    bits_c = (32'(settle_cur) + BIT_NS - 32'd1) / BIT_NS;
    skip_c = (bits_c + 32'd23) / 32'd24;
  end

  assign fr_go    = (st == S_LAUNCH);
  assign frame_in = {mk_cmd(3'(ch_lo), fidx == total - 1'b1, int_ref), 16'h0000};
  assign sample   = rx[14:3];
  assign div_go   = (st == S_DSTART);

  tscan_shifter #(.HDIV(SCLK_HDIV), .FW(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .go(fr_go), .frame_in(frame_in), .miso(miso),
    .sclk(sclk), .mosi(mosi), .active(fr_active), .fdone(fdone), .rx(rx)
  );

  tscan_cdiv #(.NW(DIVN_W), .DW(RATIO_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num({1'b0, acc}), .den(ratio_r),
    .fin(div_fin), .quo(div_q)
  );

  always_ff @(posedge clk) begin
    res_we <= 1'b0;
    done   <= 1'b0;
    if (rst) begin
      st       <= S_IDLE;
      mask     <= '0;
      ch       <= '0;
      slot     <= '0;
      fidx     <= '0;
      total    <= '0;
      skip_r   <= '0;
      ratio_r  <= '0;
      acc      <= '0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      res_slot <= '0;
      res_data <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          mask <= ch_en;
          ch   <= '0;
          slot <= '0;
          busy <= 1'b1;
          st   <= S_PICK;
        end
        S_PICK: begin
          if (ch == (AW+1)'(NCH)) begin
            st <= S_FIN;
          end else if (mask[ch_lo]) begin
            skip_r  <= CNT_W'(skip_c);
            total   <= CNT_W'(skip_c) + CNT_W'(ratio_eff);
            ratio_r <= ratio_eff;
            fidx    <= '0;
            acc     <= '0;
            cs_n    <= 1'b0;
            st      <= S_LAUNCH;
          end else begin
            ch <= ch + 1'b1;
          end
        end
        S_LAUNCH: st <= S_FRAME;
        S_FRAME: if (fdone) begin
          if (fidx >= skip_r) acc <= acc + ACC_W'(sample);
          if (fidx == total - 1'b1) begin
            st <= S_DSTART;
          end else begin
            fidx <= fidx + 1'b1;
            st   <= S_LAUNCH;
          end
        end
        S_DSTART: st <= S_DIV;
        S_DIV: if (div_fin) begin
          res_we   <= 1'b1;
          res_slot <= slot;
          res_data <= div_q[RES_W-1:0];
          slot     <= slot + 1'b1;
          ch       <= ch + 1'b1;
          st       <= S_PICK;
        end
        S_FIN: begin
          cs_n <= 1'b1;
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6: serial clock only toggles inside the chip-select window
  a_r6_sclk_in_cs: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  // R7: end-of-scan flag is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: results are only written inside an active scan
  a_r4_write_in_scan: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (busy && !cs_n));

  // R3: divider output is the rounded-up quotient of the accumulated sum
  a_r3_ceil_quotient: assert property (@(posedge clk) disable iff (rst)
    div_fin |-> ((40'(div_q) * 40'(ratio_r) >= 40'(acc)) &&
                 (div_q == '0 || (40'(div_q) - 40'd1) * 40'(ratio_r) < 40'(acc))));

  // R8: snapshot mask is held for the whole scan
  a_r8_mask_held: assert property (@(posedge clk) disable iff (rst)
    (busy && st != S_FIN) |=> $stable(mask));

endmodule

// File: tb/touch_scan_seq_tb.sv
module touch_scan_seq_tb;
  localparam int NCH = 8, SW = 16, RW = 8, HDIV = 2, BITNS = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, int_ref = 1'b0;
  logic [NCH-1:0]    ch_en = '0;
  logic [NCH*SW-1:0] settle = '0;
  logic [NCH*RW-1:0] ratio = '0;
  logic miso;
  logic sclk, mosi, cs_n, busy, done, res_we;
  logic [2:0]  res_slot;
  logic [11:0] res_data;

  always #2 clk = ~clk;

  touch_scan_seq #(.NCH(NCH), .SYS_CLK_HZ(250_000_000), .SCLK_HDIV(HDIV),
                   .SETTLE_W(SW), .RATIO_W(RW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .ch_en(ch_en), .int_ref(int_ref),
    .settle_ns(settle), .ratio(ratio), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .busy(busy), .done(done), .res_we(res_we),
    .res_slot(res_slot), .res_data(res_data));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int vmode = 0, vseed = 0;
  function automatic logic [11:0] smp(input int k);
    if (vmode == 1) return 12'hFFF;
    return 12'((k * 37 + vseed * 101 + k * k * 13) ^ (vseed >> 3));
  endfunction
  function automatic logic [23:0] mkword(input int k);
    return {8'hA5, 1'b1, smp(k), 3'b101};
  endfunction

  logic [7:0] cmd_log [300];
  logic [7:0] capcmd;
  logic [23:0] word = '0;
  int nfr = 0, bitpos = 0, cs_rise = 0, cs_fall = 0, sclk_bad = 0;
  time t_rise = 0, t_fall = 0;

  assign miso = word[23 - bitpos];

  always @(negedge cs_n) begin
    cs_fall++;
    bitpos = 0;
    word = mkword(nfr);
  end
  always @(posedge cs_n) cs_rise++;

  always @(posedge sclk) begin
    if (bitpos > 0 && ($time - t_fall) != HDIV * 4) sclk_bad++;
    t_rise = $time;
    if (bitpos < 8) capcmd = {capcmd[6:0], mosi};
  end

  always @(negedge sclk) begin
    if (($time - t_rise) != HDIV * 4) sclk_bad++;
    t_fall = $time;
    bitpos++;
    if (bitpos == 24) begin
      if (nfr < 300) cmd_log[nfr] = capcmd;
      nfr++;
      bitpos = 0;
      word = mkword(nfr);
    end
  end

  // ---------------- result monitor ----------------
  int res_arr [8];
  int slot_arr [8];
  int nres = 0, ndone = 0;
  always @(negedge clk) begin
    if (res_we) begin
      if (nres < 8) begin
        res_arr[nres]  = int'(res_data);
        slot_arr[nres] = int'(res_slot);
      end
      nres++;
    end
    if (done) ndone++;
  end

  int s_set [8];
  int s_rat [8];

  task automatic run_scan(input logic [7:0] m, input logic r, input bit poke);
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      settle[i*SW +: SW] = SW'(s_set[i]);
      ratio[i*RW +: RW]  = RW'(s_rat[i]);
    end
    ch_en = m; int_ref = r;
    nfr = 0; nres = 0; ndone = 0; cs_rise = 0; cs_fall = 0; sclk_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      ch_en = ~m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ch_en = m;
    end
    while (ndone == 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    repeat (30) @(negedge clk);
    chk(ndone == 1, "R7/R8 single done", ndone, 1);
    chk(busy == 1'b0 && cs_n == 1'b1, "R7 idle after done", int'({busy, cs_n}), 1);
    begin
      int k = 0, slot = 0;
      for (int ch = 0; ch < NCH; ch++) begin
        if (m[ch]) begin
          int bits = (s_set[ch] + BITNS - 1) / BITNS;
          int skip = (bits + 23) / 24;
          int rr   = (s_rat[ch] == 0) ? 1 : s_rat[ch];
          int tot  = skip + rr;
          int sum  = 0, exp_v;
          bit se   = (ch == 0 || ch == 2 || ch == 6 || ch == 7);
          int bad_cmd = -1;
          logic [7:0] exp_c = '0;
          for (int f = 0; f < tot; f++) begin
            bit last = (f == tot - 1);
            logic [7:0] c = {1'b1, 3'(ch), 1'b0, se, se & r & ~last, ~last};
            if (k + f < 300 && cmd_log[k + f] !== c && bad_cmd < 0) begin
              bad_cmd = f; exp_c = c;
            end
            if (f >= skip) sum += int'(smp(k + f));
          end
          if (bad_cmd >= 0)
            chk(0, "R1 command byte", int'(cmd_log[k + bad_cmd]), int'(exp_c));
          else
            chk(1, "R1 command byte", 0, 0);
          exp_v = (sum + rr - 1) / rr;
          chk(slot < nres && res_arr[slot] == exp_v, "R3 average",
              (slot < 8) ? res_arr[slot] : -1, exp_v);
          chk(slot < nres && slot_arr[slot] == slot, "R4 slot order",
              (slot < 8) ? slot_arr[slot] : -1, slot);
          k += tot;
          slot++;
        end
      end
      chk(nfr == k, "R2 frame count", nfr, k);
      chk(nres == slot, "R4 write count", nres, slot);
      chk(cs_fall == ((m != 0) ? 1 : 0) && cs_rise == cs_fall, "R6 cs window",
          cs_fall * 10 + cs_rise, (m != 0) ? 11 : 0);
      chk(sclk_bad == 0, "R5 sclk timing", sclk_bad, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0 && res_we == 1'b0,
        "R9 reset state", int'({cs_n, sclk, busy, done, res_we}), 16);

    // defaults on every input, internal reference, start poked mid-scan (R8)
    for (int i = 0; i < NCH; i++) begin s_set[i] = 1000; s_rat[i] = 1; end
    vseed = 3; run_scan(8'hFF, 1'b1, 1'b1);

    // no settling, ratio 4, uneven sum (R3 rounding)
    for (int i = 0; i < NCH; i++) begin s_set[i] = 0; s_rat[i] = 4; end
    vseed = 11; run_scan(8'h80, 1'b1, 1'b0);

    // ratio 0 treated as 1, one-bit settle gives one skip frame (R2)
    s_set[0] = 16; s_rat[0] = 0;
    run_scan(8'h01, 1'b0, 1'b0);

    // full scale, 255 samples: accumulator width (R3)
    vmode = 1; s_set[5] = 0; s_rat[5] = 255;
    run_scan(8'h20, 1'b1, 1'b0);
    vmode = 0;

    // empty mask: no chip-select activity, one done (R6, R7)
    run_scan(8'h00, 1'b0, 1'b0);

    // constrained random scans
    for (int n = 0; n < 12; n++) begin
      for (int i = 0; i < NCH; i++) begin
        s_set[i] = int'($urandom % 801);
        s_rat[i] = int'($urandom % 5);
      end
      vseed = int'($urandom % 1000);
      run_scan(8'($urandom), 1'($urandom), 1'b0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule